// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is a cycle-accurate digital model of the control logic found in a 256-element linear light sensor. A start input sampled on a rising clock edge freezes the charge of all elements into their hold stages. It then steps a pixel selector from 1 up to the element count, so that every stored value is presented once, in order. While the readout runs, a one-clock active-low pulse clears the integrators, so the next exposure begins in the background.

The last element enters hold and leaves it one clock after the rest. This is why a full line needs exactly as many clocks as there are elements. A start given while a readout is still running restarts the selector at element 1 and keeps the values already held. If clocks continue past the end of a line with no new start, the selector rests on element 1 in sample mode. A shutter input stops integration for as long as it is high. Every output comes straight from a register, so a checker can compare the outputs against an expected sequence cycle by cycle.

Top module: `lineSensorSeq`

## Requirements
- R1: While `rstN` is low, and after it is released until the first start, `pixelIdx` is 1, `pixelValid` is 0, `holdMain` and `holdLast` are 0 (sample mode), `integRstN` is 1 and `integEn` is 1.
- R2: When `si` is 1 at a rising edge and no readout is running, the outputs after that edge show `pixelIdx` = 1, `pixelValid` = 1 and `holdMain` = 1 (1 means hold).
- R3: During a readout without `si`, `pixelIdx` increases by one at each rising edge up to 256. `pixelValid` stays 1 for exactly 256 clocks, then goes to 0 with `pixelIdx` = 1.
- R4: `holdLast` rises one clock after `holdMain` rises and falls one clock after `holdMain` falls.
- R5: `holdMain` returns to 0 at the edge that selects pixel 256, once pixels 1 to 255 have been presented.
- R6: After a fresh start, `integRstN` is 0 from the 2nd to the 3rd falling edge of `clk` counted from the start edge. It is 1 at all other times.
- R7: `si` = 1 at an edge while `pixelIdx` is between 1 and 255 with `pixelValid` = 1 restarts at pixel 1. In that case `holdMain` and `holdLast` stay 1 and no `integRstN` pulse follows.
- R8: `si` = 1 at the edge following the clock that showed pixel 256 counts as a fresh start (R2, R4, R6 apply).
- R9: With no `si`, clocks after a completed line leave `pixelIdx` = 1, `pixelValid` = 0 and both hold controls at 0, for as long as the clocks continue.
- R10: After each rising edge, `integEn` equals the inverse of `dis` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| si | input | 1 | Start of readout and integration |
| dis | input | 1 | Shutter: 1 stops integration |
| pixelIdx | output | 9 | Selected pixel, 1 to 256 |
| pixelValid | output | 1 | High during the readout clocks |
| holdMain | output | 1 | Hold control for pixels 1 to 255 (1 = hold) |
| holdLast | output | 1 | Hold control for pixel 256 (1 = hold) |
| integRstN | output | 1 | Active-low integrator clear pulse |
| integEn | output | 1 | Photocurrent integration enable |

## Verification
A clean line of several hundred clocks after a single start separates correct counting, the end-of-line drop of `pixelValid` and the idle behaviour from off-by-one errors at 255 and 256. Starts placed mid-line and exactly after pixel 256 distinguish a restart, which keeps the hold state and gives no clear pulse, from a fresh start, which does both. A long random stretch with sparse starts and a toggling shutter then mixes these cases, and a bench model predicts every output at every edge.

// File: rtl/lineSensorSeq_pkg.sv
package lineSensorSeq_pkg;
  // Strobes from control to datapath, one decision per rising edge
  typedef struct packed {
    logic start;    // fresh start: sample then hold all pixels
    logic restart;  // start while a line is running: keep held values
    logic advance;  // step to the next pixel
    logic finish;   // line complete, fall back to idle
    logic endMain;  // pixels 1..N-1 done, release their hold
  } seqStrobe_t;
endpackage

// File: rtl/lineSensorSeqCtrl.sv
module lineSensorSeqCtrl
  import lineSensorSeq_pkg::*;
#(
  parameter int NUM_PIX = 256,
  localparam int IDX_W = $clog2(NUM_PIX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             si,
  input  logic [IDX_W-1:0] pixelIdx,
  input  logic             pixelValid,
  output seqStrobe_t       strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX);
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(NUM_PIX - 1);

  logic atLast;
  logic running;

  assign atLast  = pixelValid && (pixelIdx == LAST_IDX);
  assign running = pixelValid && !atLast;

  always_comb begin
    strobe         = '0;
    strobe.start   = si && !running;
    strobe.restart = si && running;
    strobe.advance = !si && running;
    strobe.finish  = !si && atLast;
    strobe.endMain = !si && running && (pixelIdx == PRE_LAST);
  end

  // R2
  start_sel_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (pixelIdx == 1) && pixelValid);

  // R3
  advance_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> pixelValid && (pixelIdx == $past(pixelIdx) + 1'b1));

  // R7
  restart_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (pixelIdx == 1) && pixelValid);
endmodule

// File: rtl/lineSensorSeqPath.sv
module lineSensorSeqPath
  import lineSensorSeq_pkg::*;
#(
  parameter int NUM_PIX  = 256,
  parameter int RST_EDGE = 2,
  localparam int IDX_W = $clog2(NUM_PIX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dis,
  input  seqStrobe_t       strobe,
  output logic [IDX_W-1:0] pixelIdx,
  output logic             pixelValid,
  output logic             holdMain,
  output logic             holdLast,
  output logic             integRstN,
  output logic             integEn
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] CLR_IDX   = IDX_W'(RST_EDGE);

  logic freshRun;

  // Pixel selector and valid flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixelIdx   <= FIRST_IDX;
      pixelValid <= 1'b0;
    end else if (strobe.start || strobe.restart) begin
      pixelIdx   <= FIRST_IDX;
      pixelValid <= 1'b1;
    end else if (strobe.advance) begin
      pixelIdx   <= pixelIdx + 1'b1;
    end else if (strobe.finish) begin
      pixelIdx   <= FIRST_IDX;
      pixelValid <= 1'b0;
    end
  end

  // Hold controls: the last pixel trails the others by one clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdMain <= 1'b0;
      holdLast <= 1'b0;
      freshRun <= 1'b0;
      integEn  <= 1'b1;
    end else begin
      holdLast <= holdMain;
      integEn  <= !dis;
      if (strobe.start) begin
        holdMain <= 1'b1;
        freshRun <= 1'b1;
      end else begin
        if (strobe.endMain) holdMain <= 1'b0;
        if (strobe.restart) freshRun <= 1'b0;
      end
    end
  end

  // Integrator clear, timed on falling edges
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) integRstN <= 1'b1;
    else       integRstN <= !(freshRun && pixelValid && (pixelIdx == CLR_IDX));
  end

  // R6
  clr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !integRstN |-> pixelValid && (pixelIdx == CLR_IDX) && holdMain);

  // R4
  last_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdMain) |=> $fell(holdLast));

  // R5
  main_hold_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdMain |-> pixelValid && (pixelIdx != IDX_W'(NUM_PIX)));

  // R9
  idle_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixelValid |-> (pixelIdx == FIRST_IDX) && !holdMain);
endmodule

// File: rtl/lineSensorSeq.sv
module lineSensorSeq
  import lineSensorSeq_pkg::*;
#(
  parameter int NUM_PIX  = 256,
  parameter int RST_EDGE = 2,
  localparam int IDX_W = $clog2(NUM_PIX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             si,
  input  logic             dis,
  output logic [IDX_W-1:0] pixelIdx,
  output logic             pixelValid,
  output logic             holdMain,
  output logic             holdLast,
  output logic             integRstN,
  output logic             integEn
);
  seqStrobe_t strobe;

  lineSensorSeqCtrl #(.NUM_PIX(NUM_PIX)) ctrl (
    .clk(clk), .rstN(rstN), .si(si),
    .pixelIdx(pixelIdx), .pixelValid(pixelValid), .strobe(strobe)
  );

  lineSensorSeqPath #(.NUM_PIX(NUM_PIX), .RST_EDGE(RST_EDGE)) path (
    .clk(clk), .rstN(rstN), .dis(dis), .strobe(strobe),
    .pixelIdx(pixelIdx), .pixelValid(pixelValid),
    .holdMain(holdMain), .holdLast(holdLast),
    .integRstN(integRstN), .integEn(integEn)
  );
endmodule

// File: tb/lineSensorSeq_test.sv
`timescale 1ns/1ps
module lineSensorSeq_test;
  localparam int NPIX = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic si = 1'b0;
  logic dis = 1'b0;
  logic [8:0] pixelIdx;
  logic pixelValid, holdMain, holdLast, integRstN, integEn;

  int checks = 0;
  int errors = 0;
  string phaseTag = "R3";

  // bench model state
  int  mPos = 0;
  bit  mHold = 0, mHoldLast = 0, mFresh = 0, mEn = 1;

  always #2 clk = ~clk;

  lineSensorSeq uut (
    .clk(clk), .rstN(rstN), .si(si), .dis(dis),
    .pixelIdx(pixelIdx), .pixelValid(pixelValid),
    .holdMain(holdMain), .holdLast(holdLast),
    .integRstN(integRstN), .integEn(integEn)
  );

  function automatic int expIdx(int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic bit expClr(int p, bit fresh);
    return !(fresh && p == 2);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit s, bit d);
    bit expR;
    bit oldHold;
    @(negedge clk);
    si = s;
    dis = d;
    @(posedge clk);
    #1;
    expR = expClr(mPos, mFresh);
    oldHold = mHold;
    if (s) begin
      if (mPos == 0 || mPos == NPIX) begin
        mFresh = 1;
        mHold = 1;
      end else begin
        mFresh = 0;
      end
      mPos = 1;
    end else if (mPos != 0) begin
      if (mPos == NPIX - 1) mHold = 0;
      mPos = (mPos == NPIX) ? 0 : mPos + 1;
    end
    mHoldLast = oldHold;
    mEn = !d;
    check({phaseTag, " pixelIdx"}, pixelIdx, expIdx(mPos));
    check({phaseTag, " pixelValid"}, pixelValid, mPos != 0);
    check("R5 holdMain", holdMain, mHold);
    check("R4 holdLast", holdLast, mHoldLast);
    check("R6 integRstN", integRstN, expR);
    check("R10 integEn", integEn, mEn);
  endtask

  task automatic runTo(int pos);
    while (mPos != pos) step(1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    // R1 during reset
    check("R1 idx", pixelIdx, 1);
    check("R1 valid", pixelValid, 0);
    check("R1 holdMain", holdMain, 0);
    check("R1 holdLast", holdLast, 0);
    check("R1 integRstN", integRstN, 1);
    check("R1 integEn", integEn, 1);
    rstN = 1'b1;
    phaseTag = "R1";
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // R2 fresh start, then R3 full line and R9 idle overrun
    phaseTag = "R2";
    step(1'b1, 1'b0);
    phaseTag = "R3";
    runTo(NPIX);
    phaseTag = "R9";
    repeat (20) step(1'b0, 1'b0);

    // R7 restart mid-line, then R8 start right after pixel 256
    phaseTag = "R2";
    step(1'b1, 1'b0);
    phaseTag = "R3";
    runTo(100);
    phaseTag = "R7";
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    phaseTag = "R7";
    runTo(255);
    step(1'b1, 1'b0);
    phaseTag = "R3";
    runTo(NPIX);
    phaseTag = "R8";
    step(1'b1, 1'b0);
    repeat (4) step(1'b0, 1'b0);

    // R10 shutter toggling
    phaseTag = "R3";
    repeat (6) step(1'b0, 1'b1);
    step(1'b0, 1'b0);

    // random mix
    phaseTag = "R3";
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 150) == 0, ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule